// File: doc/BRIEF.md
# Program Counter and Return Stack Sequencer

This block holds the program counter of a small byte-register interpreter core with 16-bit instruction words and works out where execution goes next. A fetch stage pulses `step` to advance the counter by one instruction (2 bytes). An execute stage presents a decoded instruction on `op` together with a strobe `issue`. At that point the counter already points past the instruction. The block handles every control-flow instruction: absolute and register-offset jumps, subroutine call and return, and the six conditional skips. All other instructions leave the counter alone.

The return stack lives in main memory. It grows toward lower addresses and moves by one 16-bit word (2 bytes) per entry. The block owns the stack pointer and issues its own single-cycle word requests: a write for a call, and a read for a return. It waits for the read data before it loads the counter, and holds off further instructions while it waits. A jump whose target is the jump itself is treated as a halt. It raises a sticky `halted` flag, which freezes the counter until `resume` is pulsed.

Top module: `pc_stack_seq`

## Requirements
- R1: After reset, `pc` equals RESET_PC (default 0x200), `sp` equals SP_INIT (default 0xEFE), and `halted`, `busy` and `mem_req` are 0.
- R2: A `step` pulse with no `issue` adds 2 to `pc` at the next clock edge. The sum wraps modulo 2^AW. `issue` takes priority over `step` in the same cycle.
- R3: Opcode 0x1nnn loads `pc` with nnn at the next edge.
- R4: When a 0x1nnn target plus 2 equals the current `pc` (modulo 2^AW), `pc` is loaded with nnn and `halted` rises. It stays high until a `resume` pulse clears it. While it is high, `step` and `issue` have no effect on `pc` or `sp`.
- R5: Opcode 0xBnnn loads `pc` with nnn plus the zero-extended `rx0`, wrapping modulo 2^AW.
- R6: Each of these skips adds 2 to `pc` when its condition holds, and otherwise leaves `pc` unchanged:
  - 0x3xkk skips when `rx` == kk.
  - 0x4xkk skips when `rx` != kk.
  - 0x5xy0 skips when `rx` == `ry`.
  - 0x9xy0 skips when `rx` != `ry`.
  - 0x5 and 0x9 forms whose low nibble is not 0 never skip.
- R7: 0xEx9E skips when `keys[rx[3:0]]` is 1. 0xExA1 skips when that bit is 0. Other 0xE low bytes never skip.
- R8: Opcode 0x2nnn produces, at the next edge:
  - a one-cycle write request to address `sp` (old value) with data equal to the zero-extended `pc` (old value);
  - `sp` decreased by 2;
  - `pc` loaded with nnn.
- R9: Opcode 0x00EE produces, at the next edge, `sp` increased by 2 and a one-cycle read request at that new `sp`, with `busy` raised. The edge at which `mem_rvalid` is seen loads `pc` from `mem_rdata` and clears `busy`. `issue` and `step` have no effect while `busy` is high.
- R10: Stack pointer arithmetic wraps modulo 2^AW in both directions and never saturates.
- R11: Opcodes outside the control-flow set (for example 0x6xkk, 0x8xy4, 0x0nnn other than 0x00EE) change neither `pc` nor `sp` and make no memory request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | Advance `pc` by one instruction |
| issue | input | 1 | `op` holds an instruction to execute |
| op | input | 16 | Instruction word |
| rx | input | 8 | Value of the register named by op[11:8] |
| ry | input | 8 | Value of the register named by op[7:4] |
| rx0 | input | 8 | Value of register 0 |
| keys | input | NKEY | Key pressed vector |
| resume | input | 1 | Clears the halted flag |
| mem_rdata | input | 16 | Stack read data |
| mem_rvalid | input | 1 | `mem_rdata` valid for the pending read |
| pc | output | AW | Program counter |
| sp | output | AW | Stack pointer |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Request byte address |
| mem_wdata | output | 16 | Write data |
| busy | output | 1 | Return read outstanding |
| halted | output | 1 | Self-jump halt seen |

## Verification
Every result except a return is registered once. A jump, skip, call, step or halt driven before an edge shows up on `pc`, `sp`, `halted` and the request outputs right after that single edge. The bench drives at the falling edge and samples one full cycle later. A return takes one edge to raise `busy` and the read request, then one further edge after `mem_rvalid`. The bench polls `busy` at falling edges before it compares `pc` and `sp`, and it answers reads with a delay of one or more cycles. Because of this, the bench checks for "no effect while busy" after the read completes.

// File: rtl/pc_stack_seq.sv
module pc_stack_seq #(
  parameter int          AW       = 12,
  parameter int          NKEY     = 16,
  parameter logic [AW-1:0] RESET_PC = 12'h200,
  parameter logic [AW-1:0] SP_INIT  = 12'hEFE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            step,
  input  logic            issue,
  input  logic [15:0]     op,
  input  logic [7:0]      rx,
  input  logic [7:0]      ry,
  input  logic [7:0]      rx0,
  input  logic [NKEY-1:0] keys,
  input  logic            resume,
  input  logic [15:0]     mem_rdata,
  input  logic            mem_rvalid,
  output logic [AW-1:0]   pc,
  output logic [AW-1:0]   sp,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [15:0]     mem_wdata,
  output logic            busy,
  output logic            halted
);
  localparam int KW = (NKEY > 1) ? $clog2(NKEY) : 1;
  localparam logic [AW-1:0] TWO = AW'(2);

  logic [3:0]    grp;
  logic [7:0]    imm;
  logic [AW-1:0] tgt;
  logic          key_on, live, take_skip;
  logic [AW-1:0] pc_n, sp_n, addr_n;
  logic [15:0]   wd_n;
  logic          req_n, we_n, busy_n, halt_set;

  assign grp    = op[15:12];
  assign imm    = op[7:0];
  assign tgt    = AW'(op[11:0]);
  assign key_on = keys[rx[KW-1:0]];
  assign live   = issue && !halted && !busy;

  always_comb begin
    take_skip = 1'b0;
    case (grp)
      4'h3: take_skip = (rx == imm);
      4'h4: take_skip = (rx != imm);
      4'h5: take_skip = (op[3:0] == 4'h0) && (rx == ry);
      4'h9: take_skip = (op[3:0] == 4'h0) && (rx != ry);
      4'hE: take_skip = ((imm == 8'h9E) && key_on) || ((imm == 8'hA1) && !key_on);
      default: take_skip = 1'b0;
    endcase
  end

  always_comb begin
    pc_n     = pc;
    sp_n     = sp;
    addr_n   = mem_addr;
    wd_n     = mem_wdata;
    req_n    = 1'b0;
    we_n     = 1'b0;
    busy_n   = busy;
    halt_set = 1'b0;
    if (busy) begin
      if (mem_rvalid) begin
        pc_n   = mem_rdata[AW-1:0];
        busy_n = 1'b0;
      end
    end else if (live) begin
      case (grp)
        4'h0: if (op == 16'h00EE) begin
          sp_n   = sp + TWO;
          addr_n = sp + TWO;
          req_n  = 1'b1;
          busy_n = 1'b1;
        end
        4'h1: begin
          pc_n     = tgt;
          halt_set = ((tgt + TWO) == pc);
        end
        4'h2: begin
          req_n  = 1'b1;
          we_n   = 1'b1;
          addr_n = sp;
          wd_n   = 16'(pc);
          sp_n   = sp - TWO;
          pc_n   = tgt;
        end
        4'hB: pc_n = tgt + AW'(rx0);
        default: if (take_skip) pc_n = pc + TWO;
      endcase
    end else if (step && !halted) begin
      pc_n = pc + TWO;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc        <= RESET_PC;
      sp        <= SP_INIT;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      busy      <= 1'b0;
      halted    <= 1'b0;
    end else begin
      pc        <= pc_n;
      sp        <= sp_n;
      mem_req   <= req_n;
      mem_we    <= we_n;
      mem_addr  <= addr_n;
      mem_wdata <= wd_n;
      busy      <= busy_n;
      if (resume)        halted <= 1'b0;
      else if (halt_set) halted <= 1'b1;
    end
  end
endmodule

// File: rtl/pc_stack_seq_chk.sv
module pc_stack_seq_chk #(
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          resume,
  input logic          mem_rvalid,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] sp,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          busy,
  input logic          halted
);
  p_halt_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !resume |=> halted);

  p_halt_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !resume |=> $stable(pc) && $stable(sp));

  p_push_slot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> (sp + AW'(2)) == mem_addr);

  p_pop_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |-> busy && (mem_addr == sp));

  p_pop_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_we |=> !mem_req);

  p_wait_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_rvalid |=> $stable(pc) && $stable(sp));
endmodule

bind pc_stack_seq pc_stack_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .resume(resume), .mem_rvalid(mem_rvalid),
  .pc(pc), .sp(sp), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .busy(busy), .halted(halted)
);

// File: tb/sim_pc_stack_seq.sv
`timescale 1ns/1ps
module sim_pc_stack_seq;
  localparam int AW = 12;
  logic clk = 0, rst_n = 0, step = 0, issue = 0, resume = 0, mem_rvalid = 0;
  logic [15:0] op = 0, mem_rdata = 0;
  logic [7:0] rx = 0, ry = 0, rx0 = 0;
  logic [15:0] keys = 0;
  logic [AW-1:0] pc, sp, mem_addr;
  logic [15:0] mem_wdata;
  logic mem_req, mem_we, busy, halted;

  int total = 0, bad = 0;
  logic [AW-1:0] e_pc, e_sp;
  logic [15:0] smem [0:2047];
  int lat = 1, rd_cnt = 0;
  logic [AW-1:0] rd_addr = 0;
  int n_wr = 0, n_rd = 0;
  logic [AW-1:0] last_wa = 0;
  logic [15:0] last_wd = 0;

  always #4 clk = ~clk;

  pc_stack_seq #(.AW(AW), .RESET_PC(12'h200), .SP_INIT(12'h002)) u0 (
    .clk(clk), .rst_n(rst_n), .step(step), .issue(issue), .op(op), .rx(rx), .ry(ry),
    .rx0(rx0), .keys(keys), .resume(resume), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
    .pc(pc), .sp(sp), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .busy(busy), .halted(halted));

  always @(negedge clk) begin
    mem_rvalid = 0;
    if (rd_cnt > 0) begin
      rd_cnt = rd_cnt - 1;
      if (rd_cnt == 0) begin mem_rvalid = 1; mem_rdata = smem[rd_addr[AW-1:1]]; end
    end
    if (mem_req) begin
      if (mem_we) begin
        smem[mem_addr[AW-1:1]] = mem_wdata; n_wr++; last_wa = mem_addr; last_wd = mem_wdata;
      end else begin
        rd_addr = mem_addr; rd_cnt = lat; n_rd++;
      end
    end
  end

  task automatic chk(input string rq, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", rq, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic exec(input logic [15:0] o, input logic [7:0] a, input logic [7:0] b);
    op = o; rx = a; ry = b; issue = 1;
    tick();
    issue = 0;
  endtask

  task automatic wait_idle();
    for (int g = 0; g < 40 && busy; g++) tick();
  endtask

  task automatic ret_and_check(input logic [15:0] want, input string rq);
    exec(16'h00EE, 0, 0);
    e_sp = e_sp + 12'd2;
    chk(rq, busy, 1);
    chk(rq, mem_addr, e_sp);
    wait_idle();
    e_pc = want[AW-1:0];
    chk(rq, pc, e_pc);
    chk(rq, sp, e_sp);
  endtask

  initial begin
    #(8*200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; #1;
    // R1
    chk("R1 pc", pc, 12'h200); chk("R1 sp", sp, 12'h002);
    chk("R1 halted", halted, 0); chk("R1 busy", busy, 0); chk("R1 req", mem_req, 0);
    e_pc = 12'h200; e_sp = 12'h002;

    // R2 step, and issue priority
    for (int i = 0; i < 4; i++) begin
      step = 1; tick(); step = 0; e_pc = e_pc + 12'd2;
      chk("R2 step", pc, e_pc);
    end
    step = 1; exec(16'h1ABC, 0, 0); step = 0; e_pc = 12'hABC;
    chk("R2 issue over step", pc, e_pc);

    // R3 jump sweep, avoid self targets
    for (int a = 5; a < 4096; a += 199) begin
      if (((a + 2) & 12'hFFF) != e_pc) begin
        exec(16'h1000 | 16'(a), 0, 0); e_pc = 12'(a);
        chk("R3 jump", pc, e_pc); chk("R3 halted", halted, 0);
      end
    end
    step = 1; exec(16'h1FFE, 0, 0); step = 0; e_pc = 12'hFFE;
    step = 1; tick(); step = 0; e_pc = 12'h000;
    chk("R2 wrap", pc, e_pc);

    // R5 indexed jump
    for (int v = 0; v < 256; v += 51) begin
      rx0 = 8'(v); exec(16'hBFC0, 0, 0); e_pc = 12'(12'hFC0 + v);
      chk("R5 indexed", pc, e_pc);
    end

    // R6 skips
    for (int x = 0; x < 256; x += 15) begin
      for (int k = 0; k < 256; k += 85) begin
        exec(16'h3100 | 16'(k), 8'(x), 0); if (x == k) e_pc = e_pc + 12'd2;
        chk("R6 eq imm", pc, e_pc);
        exec(16'h4100 | 16'(k), 8'(x), 0); if (x != k) e_pc = e_pc + 12'd2;
        chk("R6 ne imm", pc, e_pc);
        exec(16'h5120, 8'(x), 8'(k)); if (x == k) e_pc = e_pc + 12'd2;
        chk("R6 eq reg", pc, e_pc);
        exec(16'h9120, 8'(x), 8'(k)); if (x != k) e_pc = e_pc + 12'd2;
        chk("R6 ne reg", pc, e_pc);
      end
    end
    exec(16'h5121, 8'h33, 8'h33); chk("R6 5 low nibble", pc, e_pc);
    exec(16'h9121, 8'h33, 8'h34); chk("R6 9 low nibble", pc, e_pc);

    // R7 keys
    keys = 16'hA5C3;
    for (int k = 0; k < 16; k++) begin
      exec(16'hE19E, 8'(k) | 8'hF0, 0); if (keys[k]) e_pc = e_pc + 12'd2;
      chk("R7 pressed", pc, e_pc);
      exec(16'hE1A1, 8'(k), 0); if (!keys[k]) e_pc = e_pc + 12'd2;
      chk("R7 released", pc, e_pc);
    end
    exec(16'hE1A2, 8'h1, 0); chk("R7 other", pc, e_pc);

    // R11 non-control
    begin
      int w0 = n_wr, r0 = n_rd;
      exec(16'h6123, 0, 0); exec(16'h8124, 8'hFF, 8'hFF); exec(16'h00E0, 0, 0); exec(16'h0123, 0, 0);
      tick();
      chk("R11 pc", pc, e_pc); chk("R11 sp", sp, e_sp);
      chk("R11 no req", (n_wr - w0) + (n_rd - r0), 0);
    end

    // R8/R10 calls through the wrap
    exec(16'h2400, 0, 0);
    chk("R8 req", mem_req, 1); chk("R8 we", mem_we, 1);
    chk("R8 addr", mem_addr, e_sp); chk("R8 data", mem_wdata, 16'(e_pc));
    smem[e_sp[AW-1:1]] = 16'(e_pc);
    begin
      logic [15:0] r1, r2, r3;
      r1 = 16'(e_pc);
      e_sp = e_sp - 12'd2; e_pc = 12'h400;
      chk("R8 sp", sp, e_sp); chk("R8 pc", pc, e_pc);
      step = 1; tick(); step = 0; e_pc = e_pc + 12'd2;
      r2 = 16'(e_pc);
      exec(16'h2600, 0, 0); e_sp = e_sp - 12'd2; e_pc = 12'h600;
      chk("R10 sp wrap down", sp, 12'hFFE); chk("R10 sp", sp, e_sp);
      tick(); chk("R8 last data", last_wd, r2); chk("R8 last addr", last_wa, 12'h000);
      r3 = 16'(e_pc);
      exec(16'h2800, 0, 0); e_sp = e_sp - 12'd2; e_pc = 12'h800;
      tick(); chk("R8 wrapped addr", last_wa, 12'hFFE); chk("R8 data3", last_wd, r3);
      lat = 3;
      ret_and_check(r3, "R9 ret3");
      exec(16'h00EE, 0, 0); e_sp = e_sp + 12'd2;
      chk("R10 sp wrap up", sp, 12'h000);
      issue = 1; op = 16'h1123; step = 1; tick(); issue = 0; step = 0;
      wait_idle(); e_pc = r2[AW-1:0];
      chk("R9 ignored while busy", pc, e_pc); chk("R9 sp", sp, e_sp);
      lat = 1;
      ret_and_check(r1, "R9 ret1");
      chk("R10 sp home", sp, 12'h002);
    end

    // R4 halt
    exec(16'h1000 | 16'(e_pc - 12'd2), 0, 0); e_pc = e_pc - 12'd2;
    chk("R4 halted", halted, 1); chk("R4 pc", pc, e_pc);
    step = 1; tick(); tick(); step = 0;
    chk("R4 step blocked", pc, e_pc);
    exec(16'h1555, 0, 0); chk("R4 jump blocked", pc, e_pc);
    exec(16'h2555, 0, 0); chk("R4 call blocked", sp, e_sp); chk("R4 halted hold", halted, 1);
    resume = 1; tick(); resume = 0;
    chk("R4 resumed", halted, 0);
    step = 1; tick(); step = 0; e_pc = e_pc + 12'd2;
    chk("R4 step after resume", pc, e_pc);

    $display("%0d/%0d checks passed", total - bad, total);
    $finish;
  end
endmodule